// File: doc/BRIEF.md
# Receive Frame FIFO with Store-and-Forward and Cut-Through Release

The block buffers received frames between a byte-wide receive stream and a consumer that reads bytes with a valid/ready handshake. Each frame is written with a start tag on its first byte and an end tag on its last byte. The last byte also carries the frame's error status. On the read side every byte is presented with start and end markers. The end beat also carries the frame's error class.

Two release modes are available. In store-and-forward mode the reader sees nothing of a frame until its last byte is stored. Because of this, a frame that is to be dropped can be removed by rewinding the write pointer. In cut-through mode the reader may start once the frame has reached a programmable fill threshold. Once reading has started, a late error can only be reported, not removed. A drop policy selects which erroneous frames are discarded. That policy has a separate setting for frames whose only fault is a failed payload checksum.

Top module: `rx_frame_fwd`

## Requirements
- R1: With `cfg_store_fwd`=1, no byte of a frame becomes readable (`rd_valid` stays 0) until the frame's end byte has been written. The threshold code has no effect in this mode.
- R2: With `cfg_store_fwd`=0, `rd_valid` rises right after the clock edge that stores byte number 32*(`cfg_thresh`+1) of the frame, where `cfg_thresh` is 0..3. It stays low before that byte.
- R3: With `cfg_fwd_err`=0 and `cfg_keep_csum`=0, a frame with any error class other than 0 is discarded completely in the following cases:
  - in store-and-forward mode;
  - in cut-through mode, when its end byte arrives before the threshold is reached.
- R4: With `cfg_keep_csum`=1, frames with error class 2 (payload checksum only) are kept. Frames with a MAC-level error (class 1) are still dropped while `cfg_fwd_err`=0.
- R5: With `cfg_fwd_err`=1, every frame is kept whatever its error class.
- R6: In cut-through mode, an error on a frame whose reading has already been enabled does not remove the frame. The whole frame is delivered, and its class appears on the end beat.
- R7: Frame truncation on overflow:
  - A frame that would fill the 2048-byte storage is truncated. The byte written into the last free slot becomes the end beat with class 3 (overflow).
  - Later input bytes are discarded until the input end tag.
  - The truncated frame is then subject to the drop policy as a MAC-level error.
- R8: Read beats carry `rd_sof` on a frame's first byte and `rd_eof` on its last byte.
  - `rd_cls` on the end beat gives the class: 0 none, 1 MAC error, 2 checksum-only, 3 overflow. It is 0 on every other beat.
  - The input error code 3 is stored as class 1.
- R9: Bytes leave in write order. While `rd_valid`=1 and `rd_ready`=0, the read outputs hold their values.
- R10: After reset, `rd_valid` is 0.
- R11: Input bytes received outside a frame (no start tag while idle) are ignored. The mode and threshold are captured on a frame's start byte, so changes made later in that frame have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_err | input | 2 | Error code, sampled with the end byte |
| cfg_store_fwd | input | 1 | 1 selects store-and-forward, 0 selects cut-through |
| cfg_thresh | input | 2 | Cut-through threshold code (32*(code+1) bytes) |
| cfg_keep_csum | input | 1 | Keep checksum-only error frames |
| cfg_fwd_err | input | 1 | Keep all error frames |
| rd_ready | input | 1 | Consumer accepts the current beat |
| rd_valid | output | 1 | A committed byte is available |
| rd_data | output | 8 | Read byte |
| rd_sof | output | 1 | Read beat is a frame start |
| rd_eof | output | 1 | Read beat is a frame end |
| rd_cls | output | 2 | Error class on the end beat |

## Verification
The write controller commits bytes on the same edge that stores them. As a result, `rd_valid` changes right after the edge that writes the threshold byte (cut-through) or the end byte (store-and-forward). The read beat is taken from storage with no further register stage. The bench drives each input byte on a falling edge and samples `rd_valid` on the following falling edge. At that point it compares the count of bytes stored so far with the release point. A scoreboard compares each beat taken with its prediction. It samples the handshake shortly after the falling edge, so a beat counts as taken at the next rising edge.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_MAC  = 2'd1,
        CLS_CSUM = 2'd2,
        CLS_OVF  = 2'd3
    } err_cls_e;

    typedef struct packed {
        logic     sof;
        logic     eof;
        err_cls_e cls;
        logic [7:0] data;
    } rxf_word_t;

    typedef enum logic [1:0] {
        W_IDLE  = 2'd0,
        W_FRAME = 2'd1,
        W_TRUNC = 2'd2
    } wr_state_e;

    // Policy: drop decision from the frame's class and the two controls
    function automatic logic must_drop(err_cls_e c, logic keep_csum, logic fwd_err);
        if (fwd_err || c == CLS_NONE) return 1'b0;
        if (c == CLS_CSUM)            return !keep_csum;
        return 1'b1;
    endfunction

endpackage

// File: rtl/rxf_mem.sv
module rxf_mem #(
    parameter int DEPTH = 2048,
    parameter int WIDTH = 12,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/rxf_wr_ctrl.sv
module rxf_wr_ctrl
    import rxf_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int PW   = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          in_sof,
    input  logic          in_eof,
    input  logic [1:0]    in_err,
    input  logic          cfg_store_fwd,
    input  logic [1:0]    cfg_thresh,
    input  logic          cfg_keep_csum,
    input  logic          cfg_fwd_err,
    input  logic [PW-1:0] rd_ptr,
    output logic          mem_we,
    output rxf_word_t     mem_word,
    output logic [PW-1:0] wr_ptr,
    output logic [PW-1:0] commit_ptr,
    output logic          cur_sf
);
    wr_state_e     state, state_n;
    logic [PW-1:0] wr_n, commit_n, fstart, fstart_n, fcnt, fcnt_n, thr_q, thr_n;
    logic          sf_q, sf_n, started, started_n;
    logic [PW-1:0] occ, cur_thr, base, fcnt_c;
    logic          started_c, do_write, last_slot, drop;
    err_cls_e      cls_in, cls_w;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= W_IDLE;
            wr_ptr     <= '0;
            commit_ptr <= '0;
            fstart     <= '0;
            fcnt       <= '0;
            thr_q      <= '0;
            sf_q       <= 1'b1;
            started    <= 1'b0;
        end else begin
            state      <= state_n;
            wr_ptr     <= wr_n;
            commit_ptr <= commit_n;
            fstart     <= fstart_n;
            fcnt       <= fcnt_n;
            thr_q      <= thr_n;
            sf_q       <= sf_n;
            started    <= started_n;
        end
    end

    assign occ       = wr_ptr - rd_ptr;
    assign last_slot = (occ == PW'(DEPTH - 1));
    assign cls_in    = (in_err == 2'd3) ? CLS_MAC : err_cls_e'(in_err);

    // Next state and outputs
    always_comb begin
        state_n   = state;
        wr_n      = wr_ptr;
        commit_n  = commit_ptr;
        fstart_n  = fstart;
        fcnt_n    = fcnt;
        thr_n     = thr_q;
        sf_n      = sf_q;
        started_n = started;
        do_write  = 1'b0;
        drop      = 1'b0;
        cls_w     = CLS_NONE;
        mem_word  = '0;

        cur_sf    = (state == W_IDLE) ? cfg_store_fwd : sf_q;
        cur_thr   = (state == W_IDLE) ? ((PW'(cfg_thresh) + PW'(1)) << 5) : thr_q;
        base      = (state == W_IDLE) ? wr_ptr : fstart;
        fcnt_c    = (state == W_IDLE) ? '0 : fcnt;
        started_c = (state == W_IDLE) ? 1'b0 : started;

        if (in_valid) begin
            unique case (state)
                W_IDLE: begin
                    if (in_sof) begin
                        if (occ == PW'(DEPTH)) state_n = in_eof ? W_IDLE : W_TRUNC;
                        else                   do_write = 1'b1;
                    end
                end
                W_FRAME: do_write = 1'b1;
                W_TRUNC: if (in_eof) state_n = W_IDLE;
                default: state_n = W_IDLE;
            endcase
        end

        mem_we        = do_write;
        mem_word.data = in_data;
        mem_word.sof  = (state == W_IDLE);

        if (do_write) begin
            if (in_eof || last_slot) begin
                cls_w        = in_eof ? cls_in : CLS_OVF;
                mem_word.eof = 1'b1;
                mem_word.cls = cls_w;
                drop = must_drop(cls_w, cfg_keep_csum, cfg_fwd_err) && (cur_sf || !started_c);
                if (drop) begin
                    wr_n = base;
                end else begin
                    wr_n     = wr_ptr + PW'(1);
                    commit_n = wr_ptr + PW'(1);
                end
                started_n = 1'b0;
                fcnt_n    = '0;
                state_n   = in_eof ? W_IDLE : W_TRUNC;
            end else begin
                wr_n    = wr_ptr + PW'(1);
                fcnt_n  = fcnt_c + PW'(1);
                state_n = W_FRAME;
                if (state == W_IDLE) begin
                    sf_n     = cfg_store_fwd;
                    thr_n    = cur_thr;
                    fstart_n = wr_ptr;
                end
                if (!cur_sf && (started_c || (fcnt_c + PW'(1)) >= cur_thr)) begin
                    commit_n  = wr_ptr + PW'(1);
                    started_n = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rx_frame_fwd.sv
module rx_frame_fwd
    import rxf_pkg::*;
#(
    parameter int DEPTH = 2048,
    localparam int PW   = $clog2(DEPTH) + 1,
    localparam int WW   = $bits(rxf_word_t)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    input  logic       in_sof,
    input  logic       in_eof,
    input  logic [1:0] in_err,
    input  logic       cfg_store_fwd,
    input  logic [1:0] cfg_thresh,
    input  logic       cfg_keep_csum,
    input  logic       cfg_fwd_err,
    input  logic       rd_ready,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    output logic       rd_sof,
    output logic       rd_eof,
    output logic [1:0] rd_cls
);
    logic [PW-1:0] rd_ptr, wr_ptr, commit_ptr;
    logic          mem_we, cur_sf;
    rxf_word_t     mem_word, rd_word;
    logic [WW-1:0] rd_raw;

    rxf_wr_ctrl #(.DEPTH(DEPTH)) wr_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof),
        .in_eof(in_eof), .in_err(in_err),
        .cfg_store_fwd(cfg_store_fwd), .cfg_thresh(cfg_thresh),
        .cfg_keep_csum(cfg_keep_csum), .cfg_fwd_err(cfg_fwd_err),
        .rd_ptr(rd_ptr), .mem_we(mem_we), .mem_word(mem_word),
        .wr_ptr(wr_ptr), .commit_ptr(commit_ptr), .cur_sf(cur_sf)
    );

    rxf_mem #(.DEPTH(DEPTH), .WIDTH(WW)) mem_i (
        .clk(clk), .we(mem_we), .waddr(wr_ptr[PW-2:0]), .wdata(mem_word),
        .raddr(rd_ptr[PW-2:0]), .rdata(rd_raw)
    );

    assign rd_word  = rxf_word_t'(rd_raw);
    assign rd_valid = (rd_ptr != commit_ptr);
    assign rd_data  = rd_word.data;
    assign rd_sof   = rd_word.sof;
    assign rd_eof   = rd_word.eof;
    assign rd_cls   = rd_word.cls;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    rd_ptr <= '0;
        else if (rd_valid && rd_ready) rd_ptr <= rd_ptr + PW'(1);
    end
endmodule

// File: rtl/rx_frame_fwd_chk.sv
module rx_frame_fwd_chk #(
    parameter int DEPTH = 2048,
    parameter int PW    = 12
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_valid,
    input logic          rd_ready,
    input logic [7:0]    rd_data,
    input logic          rd_sof,
    input logic          rd_eof,
    input logic [1:0]    rd_cls,
    input logic [PW-1:0] wr_ptr,
    input logic [PW-1:0] rd_ptr,
    input logic [PW-1:0] commit_ptr,
    input logic          mem_we,
    input logic          wr_eof,
    input logic          cur_sf
);
    logic [PW-1:0] occ, avail;
    assign occ   = wr_ptr - rd_ptr;
    assign avail = commit_ptr - rd_ptr;

    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= PW'(DEPTH));

    p_commit_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        avail <= occ);

    p_stall_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data) && $stable(rd_sof)
                                  && $stable(rd_eof) && $stable(rd_cls));

    p_sf_hold_commit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we && !wr_eof && cur_sf |=> $stable(commit_ptr));

    p_mid_beat_class_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_eof |-> rd_cls == 2'd0);
endmodule

bind rx_frame_fwd rx_frame_fwd_chk #(.DEPTH(DEPTH), .PW(PW)) chk_i (
    .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .rd_sof(rd_sof), .rd_eof(rd_eof), .rd_cls(rd_cls),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .commit_ptr(commit_ptr),
    .mem_we(mem_we), .wr_eof(mem_word.eof), .cur_sf(cur_sf)
);

// File: tb/rx_frame_fwd_tb_top.sv
module rx_frame_fwd_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 2048;

    logic clk = 1'b0, rst_n = 1'b0;
    logic in_valid = 0, in_sof = 0, in_eof = 0;
    logic [7:0] in_data = '0;
    logic [1:0] in_err = '0, cfg_thresh = '0;
    logic cfg_store_fwd = 1, cfg_keep_csum = 0, cfg_fwd_err = 0, rd_ready = 0;
    logic rd_valid, rd_sof, rd_eof;
    logic [7:0] rd_data;
    logic [1:0] rd_cls;

    int n_checks = 0, n_errs = 0;
    logic [11:0] exp_q[$];
    logic stalled = 0;
    logic [11:0] stall_word;

    rx_frame_fwd #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .in_err(in_err),
        .cfg_store_fwd(cfg_store_fwd), .cfg_thresh(cfg_thresh),
        .cfg_keep_csum(cfg_keep_csum), .cfg_fwd_err(cfg_fwd_err),
        .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_sof(rd_sof), .rd_eof(rd_eof), .rd_cls(rd_cls)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    endtask

    // Monitor / scoreboard: R8 beat layout {sof, eof, cls, data}, R9 order and hold
    always @(negedge clk) begin
        logic [11:0] w, e;
        #1;
        if (rst_n) begin
            w = {rd_sof, rd_eof, rd_cls, rd_data};
            if (stalled)
                check(rd_valid && w == stall_word, "R9", "held beat", int'(w), int'(stall_word));
            stalled = 0;
            if (rd_valid && rd_ready) begin
                if (exp_q.size() == 0) check(0, "R8", "unexpected beat", int'(w), -1);
                else begin
                    e = exp_q.pop_front();
                    check(w == e, "R8", "beat content", int'(w), int'(e));
                end
            end else if (rd_valid) begin
                stalled    = 1;
                stall_word = w;
            end
        end
    end

    // Driver: predicts the outcome and queues expected beats
    task automatic send(input int len, input int cls, input bit sf, input int code,
                        input bit keep, input bit fwd, input bit tchk, input bit flip,
                        input int seed, input string req);
        int  thr;
        bit  errdrop, drop, vis;
        thr     = 32 * (code + 1);
        errdrop = (cls != 0) && !fwd && !(cls == 2 && keep);
        drop    = errdrop && (sf || len <= thr);
        @(negedge clk);
        cfg_store_fwd = sf; cfg_thresh = 2'(code); cfg_keep_csum = keep; cfg_fwd_err = fwd;
        if (!drop)
            for (int i = 0; i < len; i++)
                exp_q.push_back({i == 0, i == len - 1,
                                 (i == len - 1) ? ((cls == 3) ? 2'd1 : 2'(cls)) : 2'd0,
                                 8'((seed + i * 7) & 255)});
        for (int i = 0; i <= len; i++) begin
            if (i > 0) @(negedge clk);
            if (tchk && i > 0) begin
                vis = (i == len) ? !drop : (!sf && i >= thr);
                check(rd_valid == vis, req, $sformatf("release after %0d bytes", i),
                      int'(rd_valid), int'(vis));
            end
            if (i == 1 && flip) cfg_store_fwd = !sf;
            if (i < len) begin
                in_valid = 1; in_data = 8'((seed + i * 7) & 255);
                in_sof = (i == 0); in_eof = (i == len - 1);
                in_err = (i == len - 1) ? 2'(cls) : 2'd0;
            end else begin
                in_valid = 0; in_sof = 0; in_eof = 0; in_err = 0;
            end
        end
    endtask

    task automatic drain(input string req);
        int k = 0;
        while (exp_q.size() != 0 && k < 20000) begin
            @(negedge clk);
            rd_ready = (k % 4 != 3);
            k++;
        end
        @(negedge clk);
        rd_ready = 0;
        check(exp_q.size() == 0, req, "all expected beats delivered", exp_q.size(), 0);
        @(negedge clk);
        check(rd_valid == 0, req, "nothing extra readable", int'(rd_valid), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        check(0, "WD", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check(rd_valid == 0, "R10", "rd_valid after reset", int'(rd_valid), 0);

        // R1 store-and-forward release, threshold ignored
        send(40, 0, 1, 0, 0, 0, 1, 0, 3, "R1");  drain("R1");
        // R2 cut-through thresholds 64 and 128
        send(100, 0, 0, 1, 0, 0, 1, 0, 11, "R2"); drain("R2");
        send(150, 0, 0, 3, 0, 0, 1, 0, 29, "R2"); drain("R2");
        // R3 drop of error frames
        send(60, 1, 1, 0, 0, 0, 1, 0, 5, "R3");  drain("R3");
        send(20, 2, 0, 0, 0, 0, 1, 0, 9, "R3");  drain("R3");
        send(30, 3, 1, 0, 0, 0, 1, 0, 13, "R3"); drain("R3");
        // R4 keep checksum-only, still drop MAC error
        send(50, 2, 1, 0, 1, 0, 1, 0, 17, "R4");
        send(50, 1, 1, 0, 1, 0, 0, 0, 19, "R4"); drain("R4");
        // R5 forward everything
        send(45, 1, 1, 0, 0, 1, 1, 0, 23, "R5"); drain("R5");
        // R6 late error in cut-through
        send(80, 1, 0, 0, 0, 0, 1, 0, 31, "R6"); drain("R6");
        // R11 stray bytes ignored
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); in_valid = 1; in_data = 8'(i); in_sof = 0; in_eof = (i == 4);
        end
        @(negedge clk); in_valid = 0; in_eof = 0;
        drain("R11");
        // R11 mode captured at start byte
        send(70, 0, 1, 0, 0, 0, 1, 1, 37, "R11"); drain("R11");

        // R7 overflow kept with forwarding enabled
        @(negedge clk);
        cfg_store_fwd = 1; cfg_fwd_err = 1; cfg_keep_csum = 0;
        for (int i = 0; i < DEPTH; i++)
            exp_q.push_back({i == 0, i == DEPTH - 1, (i == DEPTH - 1) ? 2'd3 : 2'd0, 8'(i)});
        for (int i = 0; i < 2100; i++) begin
            @(negedge clk); in_valid = 1; in_data = 8'(i); in_sof = (i == 0);
            in_eof = (i == 2099); in_err = 0;
        end
        @(negedge clk); in_valid = 0; in_sof = 0; in_eof = 0;
        check(rd_valid == 1, "R7", "truncated frame readable", int'(rd_valid), 1);
        drain("R7");
        // R7 overflow dropped without forwarding
        @(negedge clk);
        cfg_fwd_err = 0;
        for (int i = 0; i < 2100; i++) begin
            @(negedge clk); in_valid = 1; in_data = 8'(i); in_sof = (i == 0);
            in_eof = (i == 2099); in_err = 0;
        end
        @(negedge clk); in_valid = 0; in_sof = 0; in_eof = 0;
        check(rd_valid == 0, "R7", "overflow frame dropped", int'(rd_valid), 0);
        send(10, 0, 1, 0, 0, 0, 1, 0, 41, "R7"); drain("R7");

        report();
    end
endmodule